// File: doc/BRIEF.md
# Dual-Clock Packet Stream FIFO

This block carries a byte-wide packet stream from one clock domain into another clock domain. The two clocks have no fixed relation. Each stored entry holds one payload byte and two packet delimiters: a start-of-packet flag and an end-of-packet flag. Because the flags are stored in the same entry as their byte, a packet leaves the read side with the same framing it had on the write side.

Both sides use a valid/ready handshake. The write side takes a word only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low only while the storage is full. The read side hands a word on only in a cycle where `m_valid` and `m_ready` are both high. A reader that keeps `m_ready` low can stall the stream for as long as it likes. The front word then stays on the outputs, and the words behind it stay stored.

The read and write pointers are one bit wider than the address. They cross between the domains in Gray code through flop synchronizers. The head word of the read side sits in an output register, so every output of the block comes from a flop. Each side has its own synchronous reset.

Top module: `pkt_cdc_fifo`

## Requirements
- R1: While a side's reset is held, and in the cycles that follow it, that side reads as empty: `s_ready` is 1 after `w_rst`, and `m_valid` is 0 after `r_rst`.
- R2: A word offered with `s_valid`=1 while `s_ready`=0 is not stored, and it never appears on the read side.
- R3: Accepted words leave the read side in the order they were accepted, with their 8-bit data unchanged.
- R4: The flags `first` and `last` leave the block on the same word they entered with. A flag that is high for only a single write-side cycle is never lost and never duplicated, so the counts of first and last flags match between the two sides.
- R5: While `m_valid`=1 and `m_ready`=0, the signals `m_valid`, `m_data`, `m_first` and `m_last` keep their values, and no word is consumed.
- R6: With the reader stalled, the block accepts exactly DEPTH+1 words (DEPTH = 2^ADDR_W, 16 by default; DEPTH entries in storage plus one in the output register), and `s_ready` then stays 0.
- R7: Transfers stay correct whether the read clock is faster or slower than the write clock. Each Gray pointer that crosses between the domains changes by at most one bit per cycle of its own clock.
- R8: After a stall ends, every stored word is delivered, and `s_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Write-side clock |
| w_rst | input | 1 | Write-side synchronous reset, active high |
| s_valid | input | 1 | Write side offers a word |
| s_ready | output | 1 | Storage has room; the word is taken when `s_valid` is also high |
| s_first | input | 1 | Offered word starts a packet |
| s_last | input | 1 | Offered word ends a packet |
| s_data | input | DATA_W | Offered payload byte |
| r_clk | input | 1 | Read-side clock |
| r_rst | input | 1 | Read-side synchronous reset, active high |
| m_valid | output | 1 | A word is present on the read side |
| m_ready | input | 1 | Reader takes the presented word |
| m_first | output | 1 | Presented word starts a packet |
| m_last | output | 1 | Presented word ends a packet |
| m_data | output | DATA_W | Presented payload byte |

## Verification
The assertions check on every cycle that the outputs hold while the reader is stalled, that each side comes out of reset empty, that each crossing Gray pointer steps by at most one bit, and that the occupancy seen from either side never exceeds the depth. Other properties span many cycles or both clocks, and only the bench scenarios can show them: that the data and the flags arrive in order and aligned, that exactly DEPTH+1 words fit behind a stalled reader, that a word offered while full is really discarded, and that first/last counts balance at read periods both shorter and longer than the write period.

// File: rtl/pkt_cdc_pkg.sv
`timescale 1ns/1ps
package pkt_cdc_pkg;

  // Packet delimiters stored next to every payload word
  typedef struct packed {
    logic first;
    logic last;
  } pkt_flags_t;

  localparam int FLAG_W = $bits(pkt_flags_t);

endpackage

// File: rtl/pkt_cdc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a Gray-coded pointer
module pkt_cdc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pkt_cdc_mem.sv
`timescale 1ns/1ps
// Storage array: synchronous write in the write domain, read port addressed from the read domain
module pkt_cdc_mem #(
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 10
) (
  input  logic               w_clk,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [ENTRY_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge w_clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/pkt_cdc_wside.sv
`timescale 1ns/1ps
// Write-domain pointer logic and registered full flag
module pkt_cdc_wside #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] full_pattern;
  logic          full_q, full_d, wr_fire;

  assign wr_fire = push_req & ~full_q;

  // Full: the write pointer is a whole lap ahead of the read pointer
  assign full_pattern = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};

  always_comb begin
    wbin_d  = wbin_q + PW'(wr_fire);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    full_d  = (wgray_d == full_pattern);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
    end
  end

  assign ready = ~full_q;
  assign wr_en = wr_fire;
  assign waddr = wbin_q[ADDR_W-1:0];
  assign wgray = wgray_q;

endmodule

// File: rtl/pkt_cdc_rside.sv
`timescale 1ns/1ps
// Read-domain pointer logic with a registered head word
module pkt_cdc_rside #(
  parameter int ADDR_W  = 4,
  parameter int ENTRY_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W:0]    wgray_sync,
  input  logic               pop_ready,
  input  logic [ENTRY_W-1:0] rd_word,
  output logic [ADDR_W-1:0]  raddr,
  output logic [ADDR_W:0]    rgray,
  output logic               out_valid,
  output logic [ENTRY_W-1:0] out_word
);

  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]      rbin_q, rbin_d, rgray_q, rgray_d;
  logic               ovalid_q, empty, load;
  logic [ENTRY_W-1:0] oword_q;

  assign empty = (rgray_q == wgray_sync);
  // Refill the head register when it is free or being taken this cycle
  assign load  = ~empty & (~ovalid_q | pop_ready);

  always_comb begin
    rbin_d  = rbin_q + PW'(load);
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      ovalid_q <= 1'b0;
      oword_q  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      if (load) begin
        oword_q  <= rd_word;
        ovalid_q <= 1'b1;
      end else if (pop_ready) begin
        ovalid_q <= 1'b0;
      end
    end
  end

  assign raddr     = rbin_q[ADDR_W-1:0];
  assign rgray     = rgray_q;
  assign out_valid = ovalid_q;
  assign out_word  = oword_q;

endmodule

// File: rtl/pkt_cdc_fifo.sv
`timescale 1ns/1ps
module pkt_cdc_fifo
  import pkt_cdc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              w_clk,
  input  logic              w_rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_first,
  input  logic              s_last,
  input  logic [DATA_W-1:0] s_data,
  input  logic              r_clk,
  input  logic              r_rst,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_first,
  output logic              m_last,
  output logic [DATA_W-1:0] m_data
);

  localparam int PW      = ADDR_W + 1;
  localparam int ENTRY_W = DATA_W + FLAG_W;

  if (ADDR_W < 2) begin : g_bad_depth
    $error("pkt_cdc_fifo needs ADDR_W of at least 2");
  end

  pkt_flags_t         in_flags, out_flags;
  logic [ENTRY_W-1:0] wr_entry, rd_entry, out_entry;
  logic               wr_en;
  logic [ADDR_W-1:0]  waddr, raddr;
  logic [PW-1:0]      wgray, rgray, wgray_rs, rgray_ws;

  assign in_flags = '{first: s_first, last: s_last};
  assign wr_entry = {in_flags, s_data};

  pkt_cdc_wside #(.ADDR_W(ADDR_W)) u_wside (
    .clk        (w_clk),
    .rst        (w_rst),
    .push_req   (s_valid),
    .rgray_sync (rgray_ws),
    .ready      (s_ready),
    .wr_en      (wr_en),
    .waddr      (waddr),
    .wgray      (wgray)
  );

  pkt_cdc_mem #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_mem (
    .w_clk (w_clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (wr_entry),
    .raddr (raddr),
    .rdata (rd_entry)
  );

  pkt_cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk (r_clk),
    .rst (r_rst),
    .d   (wgray),
    .q   (wgray_rs)
  );

  pkt_cdc_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk (w_clk),
    .rst (w_rst),
    .d   (rgray),
    .q   (rgray_ws)
  );

  pkt_cdc_rside #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_rside (
    .clk        (r_clk),
    .rst        (r_rst),
    .wgray_sync (wgray_rs),
    .pop_ready  (m_ready),
    .rd_word    (rd_entry),
    .raddr      (raddr),
    .rgray      (rgray),
    .out_valid  (m_valid),
    .out_word   (out_entry)
  );

  assign out_flags = out_entry[ENTRY_W-1 -: FLAG_W];
  assign m_first   = out_flags.first;
  assign m_last    = out_flags.last;
  assign m_data    = out_entry[DATA_W-1:0];

endmodule

// File: rtl/pkt_cdc_fifo_chk.sv
`timescale 1ns/1ps
module pkt_cdc_fifo_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              w_clk,
  input logic              w_rst,
  input logic              r_clk,
  input logic              r_rst,
  input logic              s_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_first,
  input logic              m_last,
  input logic [DATA_W-1:0] m_data,
  input logic [ADDR_W:0]   wgray,
  input logic [ADDR_W:0]   rgray,
  input logic [ADDR_W:0]   wgray_rs,
  input logic [ADDR_W:0]   rgray_ws
);

  localparam int            PW      = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rd_occ, wr_occ;
  assign rd_occ = g2b(wgray_rs) - g2b(rgray);
  assign wr_occ = g2b(wgray) - g2b(rgray_ws);

  assert_reset_empty_rd_R1: assert property (@(posedge r_clk) disable iff (r_rst)
    $fell(r_rst) |-> !m_valid);

  assert_reset_empty_wr_R1: assert property (@(posedge w_clk) disable iff (w_rst)
    $fell(w_rst) |-> s_ready);

  assert_hold_stalled_R5: assert property (@(posedge r_clk) disable iff (r_rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first) && $stable(m_last)));

  assert_wgray_step_R7: assert property (@(posedge w_clk) disable iff (w_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R7: assert property (@(posedge r_clk) disable iff (r_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_rd_occupancy_R6: assert property (@(posedge r_clk) disable iff (r_rst)
    rd_occ <= DEPTH_P);

  assert_wr_occupancy_R6: assert property (@(posedge w_clk) disable iff (w_rst)
    wr_occ <= DEPTH_P);

endmodule

bind pkt_cdc_fifo pkt_cdc_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .w_clk    (w_clk),
  .w_rst    (w_rst),
  .r_clk    (r_clk),
  .r_rst    (r_rst),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_first  (m_first),
  .m_last   (m_last),
  .m_data   (m_data),
  .wgray    (wgray),
  .rgray    (rgray),
  .wgray_rs (wgray_rs),
  .rgray_ws (rgray_ws)
);

// File: tb/tb_pkt_cdc_fifo.sv
`timescale 1ns/1ps
module tb_pkt_cdc_fifo;

  localparam int DEPTH = 16;
  localparam int NVEC  = 16;
  // Entry coding used by the bench: bit 9 = first, bit 8 = last, bits 7:0 = data
  localparam logic [9:0] VEC [NVEC] = '{
    10'h211, 10'h022, 10'h033, 10'h144,
    10'h35A,
    10'h2A0, 10'h0A1, 10'h0A2, 10'h0A3, 10'h0A4, 10'h1A5,
    10'h3C3,
    10'h2F0, 10'h00F, 10'h0FF, 10'h100
  };

  logic       w_clk = 1'b0, r_clk = 1'b0;
  logic       w_rst = 1'b1, r_rst = 1'b1;
  logic       s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic       m_ready = 1'b0;
  logic       s_ready, m_valid, m_first, m_last;
  logic [7:0] m_data;

  real r_half = 6.3;
  int  rd_mode = 1;        // 0 stall, 1 always ready, 2 pseudo-random ready
  logic [7:0] lfsr = 8'hA5;

  int n_chk = 0, n_bad = 0;
  int tx_first = 0, tx_last = 0, rx_first = 0, rx_last = 0;
  logic [9:0] exp_q [$];

  always #10 w_clk = ~w_clk;
  always #(r_half) r_clk = ~r_clk;

  pkt_cdc_fifo dut (
    .w_clk(w_clk), .w_rst(w_rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_first(s_first), .s_last(s_last), .s_data(s_data),
    .r_clk(r_clk), .r_rst(r_rst), .m_valid(m_valid), .m_ready(m_ready),
    .m_first(m_first), .m_last(m_last), .m_data(m_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reader: decide ready at the falling edge, record the transfer of the next rising edge
  always @(negedge r_clk) begin
    case (rd_mode)
      0:       m_ready = 1'b0;
      1:       m_ready = 1'b1;
      default: m_ready = lfsr[0] | lfsr[3];
    endcase
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (!r_rst && m_valid) begin
      if (rd_mode == 0 && exp_q.size() > 0)
        check({m_first, m_last, m_data} == exp_q[0], "R5 stalled word held",
              {22'd0, m_first, m_last, m_data}, {22'd0, exp_q[0]});
      if (m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", {22'd0, m_first, m_last, m_data}, 32'd0);
        end else begin
          check({m_first, m_last, m_data} == exp_q[0], "R3 R4 word order and flags",
                {22'd0, m_first, m_last, m_data}, {22'd0, exp_q[0]});
          void'(exp_q.pop_front());
        end
        rx_first += int'(m_first);
        rx_last  += int'(m_last);
      end
    end
  end

  // Call at a write-side falling edge; returns at the falling edge after acceptance
  task automatic send_word(input logic [9:0] w);
    {s_first, s_last, s_data} = w;
    s_valid = 1'b1;
    while (!s_ready) @(negedge w_clk);
    exp_q.push_back(w);
    tx_first += int'(w[9]);
    tx_last  += int'(w[8]);
    @(negedge w_clk);
    s_valid = 1'b0;
    s_first = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 4000) begin
      @(negedge w_clk);
      guard++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic run_packets(input int npk);
    for (int p = 0; p < npk; p++) begin
      int len = (p % 4) + 1;
      for (int i = 0; i < len; i++)
        send_word({(i == 0), (i == len - 1), 8'(p * 16 + i)});
      repeat (p % 3) @(negedge w_clk);
    end
  endtask

  task automatic apply_reset();
    @(negedge w_clk) w_rst = 1'b1;
    @(negedge r_clk) r_rst = 1'b1;
    repeat (6) @(negedge w_clk);
    exp_q.delete();
    @(negedge w_clk) w_rst = 1'b0;
    @(negedge r_clk) r_rst = 1'b0;
    @(negedge w_clk);
    check(s_ready == 1'b1, "R1 write side empty after reset", s_ready, 1);
    @(negedge r_clk);
    check(m_valid == 1'b0, "R1 read side empty after reset", m_valid, 0);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int acc;
    // Reset state
    apply_reset();

    // Vector table, read clock faster than write clock
    rd_mode = 1;
    @(negedge w_clk);
    for (int v = 0; v < NVEC; v++) send_word(VEC[v]);
    drain("R3 vector table delivered");

    // Stalled reader fills the storage
    rd_mode = 0;
    repeat (4) @(negedge r_clk);
    @(negedge w_clk);
    acc = 0;
    for (int c = 0; c < 200; c++) begin
      {s_first, s_last, s_data} = {(acc == 0), (acc == DEPTH), 8'(8'h40 + acc)};
      s_valid = 1'b1;
      if (s_ready) begin
        exp_q.push_back({(acc == 0), (acc == DEPTH), 8'(8'h40 + acc)});
        tx_first += int'(acc == 0);
        tx_last  += int'(acc == DEPTH);
        acc++;
      end
      @(negedge w_clk);
    end
    s_valid = 1'b0;
    s_first = 1'b0;
    s_last  = 1'b0;
    check(acc == DEPTH + 1, "R6 words accepted behind stalled reader", acc, DEPTH + 1);
    check(s_ready == 1'b0, "R6 ready low when full", s_ready, 0);
    // Offer an extra word for a single cycle while full
    check(s_ready == 1'b0, "R2 ready low before ignored offer", s_ready, 0);
    {s_first, s_last, s_data} = 10'h3EE;
    s_valid = 1'b1;
    @(negedge w_clk);
    s_valid = 1'b0;
    s_first = 1'b0;
    s_last  = 1'b0;
    repeat (20) @(negedge w_clk);
    @(negedge r_clk);
    check(m_valid == 1'b1, "R5 valid held during stall", m_valid, 1);
    // Release the reader
    rd_mode = 1;
    drain("R8 stored words delivered after stall");
    repeat (50) @(negedge w_clk);
    check(s_ready == 1'b1, "R8 ready back after stall", s_ready, 1);
    @(negedge r_clk);
    check(m_valid == 1'b0, "R2 ignored word never delivered", m_valid, 0);

    // Slower read clock, random ready, single-cycle flags
    r_half  = 17.3;
    rd_mode = 2;
    repeat (4) @(negedge w_clk);
    run_packets(12);
    drain("R7 slow reader delivers all");
    // Faster read clock, random ready
    r_half = 6.3;
    repeat (4) @(negedge w_clk);
    run_packets(12);
    drain("R7 fast reader delivers all");
    repeat (10) @(negedge w_clk);
    check(rx_first == tx_first, "R4 first flag count", rx_first, tx_first);
    check(rx_last == tx_last, "R4 last flag count", rx_last, tx_last);

    // Reset with data stored
    rd_mode = 0;
    repeat (4) @(negedge r_clk);
    @(negedge w_clk);
    for (int i = 0; i < 5; i++) send_word({2'b00, 8'(8'h70 + i)});
    repeat (10) @(negedge w_clk);
    apply_reset();
    repeat (4) @(negedge r_clk);
    check(m_valid == 1'b0, "R1 reset clears stored words", m_valid, 0);
    rd_mode = 1;
    @(negedge w_clk);
    for (int v = 0; v < NVEC; v++) send_word(VEC[v]);
    drain("R3 traffic after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule